// File: doc/BRIEF.md
# Power-on reset and halt sequencer

This block produces the two active-low processor control lines for reset and halt on a 68000-style system. It does not drive the pads itself. It outputs two drive enables: a high enable means the board pad is pulled low, and a released pad floats high through its pull-up. It also reads the resolved pad levels back, because the processor can pull either line low on its own. The processor pulls the reset line when it runs its reset instruction, and it pulls the halt line after a double bus fault.

The block holds both lines for a long interval after power becomes good. That interval is `POR_MS` milliseconds, counted in cycles of a clock whose rate is the parameter `CLK_HZ`. A request from the debounced reset button holds both lines again for a short interval of `SHORT_CYCLES` cycles. The default of 10 cycles is the minimum the processor needs. Both lines are released on one clock edge.

While the lines are released, the block watches the pads. A low on the reset pad means the processor is resetting the external devices, and it shows on a flag. A low on the halt pad means the processor has stopped, and it latches a sticky status bit.

The controller has three states:
- POWERON: the long hold, entered whenever `pwr_good` is low.
- MANUAL: the short hold.
- RUN: both lines released.

Its transitions are:
- POWERON to RUN when the long count completes.
- RUN to MANUAL on a button request.
- MANUAL to MANUAL, with the count restarted, on a further request.
- MANUAL to RUN when the short count completes.
- Any state to POWERON when power drops.

Top module: `rst_halt_seq`

## Requirements
- R1: While `pwr_good` is low, both drive enables are 1 and both `ext_dev_reset` and `cpu_halted` are 0. A drop of `pwr_good` clears a set `cpu_halted` at once.
- R2: After `pwr_good` rises, both drive enables stay 1 for exactly POR_CYCLES = (CLK_HZ/1000)*POR_MS rising clock edges and are 0 after that.
- R3: When `btn_req` is 1 at a rising edge while the lines are released, both drive enables become 1 at that edge. They return to 0 exactly SHORT_CYCLES edges later.
- R4: When `btn_req` is 1 at any edge during the short hold, the hold restarts. The enables fall exactly SHORT_CYCLES edges after the last edge at which `btn_req` was 1.
- R5: `btn_req` during the power-on hold has no effect. The hold still lasts exactly POR_CYCLES edges, and a request seen on the final edge of that hold does not start a short hold.
- R6: `rst_drive_en` and `halt_drive_en` are always equal, and they fall on the same clock edge.
- R7: While the lines are released, a low on `rst_pin_n` sets `ext_dev_reset` to 1 from the next edge. The flag returns to 0 on the edge after the pad goes high. The pad low neither asserts the drive enables nor restarts any count. While the block is holding the lines, `ext_dev_reset` is 0.
- R8: While the lines are released, a low on `halt_pin_n` sets `cpu_halted` at the next edge. The bit stays set after the pad goes high, and it is cleared on the edge that starts a short hold.
- R9: A low on `halt_pin_n` while the block is holding the lines does not set `cpu_halted`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock of frequency CLK_HZ |
| pwr_good | input | 1 | Power-good level. When low, it asynchronously forces the power-on hold |
| btn_req | input | 1 | Debounced manual reset request, active high, synchronous to clk |
| rst_pin_n | input | 1 | Resolved level read back from the reset pad |
| halt_pin_n | input | 1 | Resolved level read back from the halt pad |
| rst_drive_en | output | 1 | When 1, the reset pad is pulled low |
| halt_drive_en | output | 1 | When 1, the halt pad is pulled low |
| ext_dev_reset | output | 1 | The processor is pulling the reset pad while the block has released it |
| cpu_halted | output | 1 | Sticky: the processor pulled the halt pad while it was released |

## Verification
The hardest case to reach is a button request on the final cycle of a hold. On the last edge of the power-on hold the request must be dropped, while on the last edge of a short hold it must restart the count. The stimulus walks the request pulse across every cycle offset of both holds, from the first edge to the last, and checks the full hold length each time. The bench models the open-drain pads as a wired-AND of the block's enables and the processor's pulls. This lets it pull a pad during a hold or while released, and confirm that only the released case raises a flag.

// File: rtl/rhs_pkg.sv
package rhs_pkg;

    // Controller states of the reset and halt sequencer
    typedef enum logic [1:0] {
        SEQ_POWERON = 2'd0,
        SEQ_MANUAL  = 2'd1,
        SEQ_RUN     = 2'd2
    } seq_state_e;

endpackage

// File: rtl/rhs_hold_timer.sv
module rhs_hold_timer #(
    parameter int unsigned CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          done
);

    // The count saturates at limit-1, which marks the final edge of a hold
    assign done = (count == limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (!done) begin
            count <= count + CW'(1);
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count < limit);

endmodule

// File: rtl/rhs_pin_monitor.sv
module rhs_pin_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic released,
    input  logic halt_clr,
    input  logic rst_pin_n,
    input  logic halt_pin_n,
    output logic ext_reset,
    output logic halted
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_reset <= 1'b0;
            halted    <= 1'b0;
        end else begin
            // A low pad only counts when the block itself is not driving it
            ext_reset <= released && !rst_pin_n;
            if (halt_clr) begin
                halted <= 1'b0;
            end else if (released && !halt_pin_n) begin
                halted <= 1'b1;
            end
        end
    end

    // R8
    halted_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !halt_clr) |=> halted);

    // R7
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !released |=> !ext_reset);

    // R9
    halt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!released && !halted) |=> !halted);

endmodule

// File: rtl/rst_halt_seq.sv
module rst_halt_seq
    import rhs_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 8_000_000,
    parameter int unsigned POR_MS       = 100,
    parameter int unsigned SHORT_CYCLES = 10
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic btn_req,
    input  logic rst_pin_n,
    input  logic halt_pin_n,
    output logic rst_drive_en,
    output logic halt_drive_en,
    output logic ext_dev_reset,
    output logic cpu_halted
);

    localparam int unsigned POR_CYCLES = (CLK_HZ / 1000) * POR_MS;
    localparam int unsigned LONGEST    = (POR_CYCLES > SHORT_CYCLES) ? POR_CYCLES : SHORT_CYCLES;
    localparam int unsigned CW         = $clog2(LONGEST + 1);

    seq_state_e    state, nxt;
    logic          tmr_clr;
    logic          halt_clr;
    logic          tmr_done;
    logic [CW-1:0] tmr_count;
    logic [CW-1:0] tmr_limit;
    logic          released;

    // State register: power loss forces the long hold asynchronously
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            state <= SEQ_POWERON;
        end else begin
            state <= nxt;
        end
    end

    // Next-state and timer control
    always_comb begin
        nxt      = state;
        tmr_clr  = 1'b0;
        halt_clr = 1'b0;
        unique case (state)
            SEQ_POWERON: begin
                // Button requests are ignored; the long hold runs to completion
                if (tmr_done) begin
                    nxt     = SEQ_RUN;
                    tmr_clr = 1'b1;
                end
            end
            SEQ_MANUAL: begin
                if (btn_req) begin
                    tmr_clr  = 1'b1;
                    halt_clr = 1'b1;
                end else if (tmr_done) begin
                    nxt     = SEQ_RUN;
                    tmr_clr = 1'b1;
                end
            end
            SEQ_RUN: begin
                tmr_clr = 1'b1;
                if (btn_req) begin
                    nxt      = SEQ_MANUAL;
                    halt_clr = 1'b1;
                end
            end
            default: begin
                nxt     = SEQ_POWERON;
                tmr_clr = 1'b1;
            end
        endcase
    end

    // Output decode: both lines follow one hold condition
    always_comb begin
        released      = (state == SEQ_RUN);
        rst_drive_en  = !released;
        halt_drive_en = !released;
        tmr_limit     = (state == SEQ_POWERON) ? CW'(POR_CYCLES) : CW'(SHORT_CYCLES);
    end

    rhs_hold_timer #(
        .CW (CW)
    ) u_timer (
        .clk   (clk),
        .rst_n (pwr_good),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .count (tmr_count),
        .done  (tmr_done)
    );

    rhs_pin_monitor u_monitor (
        .clk        (clk),
        .rst_n      (pwr_good),
        .released   (released),
        .halt_clr   (halt_clr),
        .rst_pin_n  (rst_pin_n),
        .halt_pin_n (halt_pin_n),
        .ext_reset  (ext_dev_reset),
        .halted     (cpu_halted)
    );

    // R5
    por_keep_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (state == SEQ_POWERON && !tmr_done) |=> (state == SEQ_POWERON));

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (state == SEQ_MANUAL && btn_req) |=> (state == SEQ_MANUAL && tmr_count == '0));

    // R6
    pair_fall_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(rst_drive_en) |-> $fell(halt_drive_en));

    // R7
    ext_no_restart_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (state == SEQ_RUN && !rst_pin_n && !btn_req) |=> (state == SEQ_RUN));

    // R3
    manual_entry_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (state == SEQ_RUN && btn_req) |=> (rst_drive_en && tmr_count == '0));

endmodule

// File: tb/rst_halt_seq_bench.sv
module rst_halt_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 20000;
    localparam int POR_MS     = 5;
    localparam int SHORT      = 10;
    localparam int POR_N      = (CLK_HZ / 1000) * POR_MS;

    logic clk = 1'b0;
    logic pwr_good = 1'b0;
    logic btn_req = 1'b0;
    logic cpu_pull_rst = 1'b0;
    logic cpu_pull_halt = 1'b0;
    logic rst_drive_en, halt_drive_en, ext_dev_reset, cpu_halted;
    logic rst_pin_n, halt_pin_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // Open-drain pads: low when either side pulls
    assign rst_pin_n  = !(rst_drive_en || cpu_pull_rst);
    assign halt_pin_n = !(halt_drive_en || cpu_pull_halt);

    rst_halt_seq #(
        .CLK_HZ       (CLK_HZ),
        .POR_MS       (POR_MS),
        .SHORT_CYCLES (SHORT)
    ) u_rst_halt_seq (
        .clk           (clk),
        .pwr_good      (pwr_good),
        .btn_req       (btn_req),
        .rst_pin_n     (rst_pin_n),
        .halt_pin_n    (halt_pin_n),
        .rst_drive_en  (rst_drive_en),
        .halt_drive_en (halt_drive_en),
        .ext_dev_reset (ext_dev_reset),
        .cpu_halted    (cpu_halted)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count negedges with the enables high, starting at the current negedge
    task automatic measure(output int n, output int mism);
        n = 0;
        mism = 0;
        while (rst_drive_en && n < 2000) begin
            if (rst_drive_en != halt_drive_en) mism++;
            n++;
            @(negedge clk);
        end
        if (rst_drive_en != halt_drive_en) mism++;
    endtask

    task automatic pulse_btn;
        btn_req = 1'b1;
        @(negedge clk);
        btn_req = 1'b0;
    endtask

    task automatic power_up;
        int n, m;
        @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        pwr_good = 1'b1;
        measure(n, m);
    endtask

    initial begin
        int n, m;
        // R1: state with power not good
        repeat (3) @(negedge clk);
        check("R1 rst_drive_en", rst_drive_en, 1);
        check("R1 halt_drive_en", halt_drive_en, 1);
        check("R1 ext_dev_reset", ext_dev_reset, 0);
        check("R1 cpu_halted", cpu_halted, 0);

        // R2 baseline and R5 sweep of button offsets across the long hold
        for (int k = -1; k < POR_N; k++) begin
            @(negedge clk);
            pwr_good = 1'b0;
            @(negedge clk);
            pwr_good = 1'b1;
            n = 0;
            m = 0;
            while (rst_drive_en && n < 2000) begin
                if (rst_drive_en != halt_drive_en) m++;
                btn_req = (n == k);
                n++;
                @(negedge clk);
            end
            btn_req = 1'b0;
            if (k < 0) check("R2 power-on hold length", n, POR_N);
            else if (n != POR_N) check("R5 power-on hold with request", n, POR_N);
            else checks++;
            if (m != 0) check("R6 enables equal", m, 0);
            if (k == POR_N - 1) begin
                @(negedge clk);
                check("R5 last-edge request ignored", rst_drive_en, 0);
                check("R6 halt released with reset", halt_drive_en, 0);
            end
        end

        // R3: single request and held request
        power_up();
        pulse_btn();
        measure(n, m);
        check("R3 short hold length", n, SHORT);
        check("R6 short hold enables equal", m, 0);
        btn_req = 1'b1;
        repeat (3) @(negedge clk);
        btn_req = 1'b0;
        measure(n, m);
        check("R4 held request hold length", n, SHORT);

        // R4: restart at every offset within the short hold
        for (int k = 0; k < SHORT; k++) begin
            pulse_btn();
            repeat (k) @(negedge clk);
            if (!rst_drive_en) check("R4 still holding before restart", rst_drive_en, 1);
            pulse_btn();
            measure(n, m);
            check("R4 restarted hold length", n, SHORT);
        end

        // R7: processor reset while released
        for (int len = 1; len <= 3; len++) begin
            @(negedge clk);
            cpu_pull_rst = 1'b1;
            repeat (len) begin
                @(negedge clk);
                check("R7 ext_dev_reset set", ext_dev_reset, 1);
                check("R7 drive stays released", rst_drive_en, 0);
            end
            cpu_pull_rst = 1'b0;
            @(negedge clk);
            check("R7 ext_dev_reset cleared", ext_dev_reset, 0);
            check("R7 no hold started", halt_drive_en, 0);
        end
        // R7: processor pull during own hold gives no flag
        pulse_btn();
        cpu_pull_rst = 1'b1;
        @(negedge clk);
        check("R7 flag quiet during hold", ext_dev_reset, 0);
        cpu_pull_rst = 1'b0;
        measure(n, m);
        check("R7 hold unaffected by processor pull", n, SHORT - 1);

        // R8: sticky halt status
        @(negedge clk);
        cpu_pull_halt = 1'b1;
        @(negedge clk);
        cpu_pull_halt = 1'b0;
        check("R8 cpu_halted set", cpu_halted, 1);
        repeat (5) @(negedge clk);
        check("R8 cpu_halted sticky", cpu_halted, 1);
        pulse_btn();
        check("R8 cpu_halted cleared by manual reset", cpu_halted, 0);

        // R9: halt pad low during own hold
        cpu_pull_halt = 1'b1;
        repeat (3) @(negedge clk);
        cpu_pull_halt = 1'b0;
        measure(n, m);
        @(negedge clk);
        check("R9 cpu_halted not set during hold", cpu_halted, 0);

        // R1: power drop clears a set status
        cpu_pull_halt = 1'b1;
        @(negedge clk);
        cpu_pull_halt = 1'b0;
        check("R8 cpu_halted set again", cpu_halted, 1);
        pwr_good = 1'b0;
        #1;
        check("R1 power drop clears cpu_halted", cpu_halted, 0);
        check("R1 power drop asserts reset", rst_drive_en, 1);
        @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule